// File: doc/BRIEF.md
# Sequential three-tap FIR filter

This block is a three-tap finite impulse response filter with fixed coefficients. It handles one sample per pass of a four-state control loop. In the first state it latches the input sample. In the second it forms all three tap products side by side, each in its own register. In the third it adds the three products into the result register, raises a ready flag and shifts the two-deep sample history. In the fourth it drops the flag again. A new sample therefore enters every four clocks, and each output is marked by a one-cycle strobe.

Samples and coefficients are unsigned 24-bit values. Each product keeps only its low 24 bits, and the sum wraps modulo 2^24. The newest sample is weighted by 0x702A78, the previous one by 0x800000 and the oldest by 0x4FD547. The reset input is asynchronous and active low. The block asserts it at once and releases it on the clock through a two-stage synchronizer.

Top module: `fir3_seq`

## Requirements
- R1: While reset is held, `result_o` is 0 and `ready_o` is 0. After reset, the sample history is zero, so the first two outputs weight only the samples that exist.
- R2: Each strobed result equals (lo24(x0*0x702A78) + lo24(x1*0x800000) + lo24(x2*0x4FD547)) mod 2^24. Here x0 is the sample just captured, x1 the one before it and x2 the one before that, and lo24 keeps the low 24 bits of the product.
- R3: The control state walks capture (2'b00), calculate (2'b10), add (2'b11), drop (2'b01), then back to capture. Successive ready strobes are exactly 4 clocks apart.
- R4: `ready_o` is high for exactly one clock per output, in the cycle after the add state.
- R5: `sample_i` is taken only at the clock edge that ends the capture state. Its value at every other edge has no effect on any result.
- R6: The history shifts only when a result is committed. The oldest takes the previous sample, and the previous takes the newly captured one.
- R7: `result_o` holds its value between strobes and changes only at the edge that raises `ready_o`.
- R8: Pulling `rst_n` low clears `result_o` and `ready_o` at once, without waiting for a clock. The loop restarts in the capture state with zero history once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sample_i | input | 24 | Unsigned input sample, latched in the capture state |
| result_o | output | 24 | Filtered output, wrapped modulo 2^24 |
| ready_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench feeds boundary samples (zero, all ones, one, the top bit alone) and then a long pseudo-random stream. Each strobed result is compared with an arithmetic model that keeps its own two-sample history. A design that shifted the history at capture instead of at commit, or that swapped two coefficients, would give wrong sums within the first three outputs. The bench also drives a changed value onto `sample_i` right after each capture edge. A design that sampled the input in any other state would then produce values from those changed inputs. Finally, the bench measures the spacing and width of the strobe, checks that the result holds between strobes, and asserts reset mid-stream. A design with a stretched flag, an extra state, or history that survives reset would be caught by the spacing checks or by the first outputs after the restart.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  localparam int unsigned FIR3_W    = 24;
  localparam int unsigned FIR3_TAPS = 3;

  // Loop order is capture -> calc -> add -> drop
  typedef enum logic [1:0] {
    ST_CAPT = 2'b00,
    ST_CALC = 2'b10,
    ST_ADD  = 2'b11,
    ST_DROP = 2'b01
  } fir3_state_e;
endpackage

// File: rtl/fir3_rst_sync.sv
module fir3_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fir3_ctrl.sv
module fir3_ctrl
  import fir3_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  output fir3_state_e state_o,
  output logic        cap_en_o,
  output logic        calc_en_o,
  output logic        add_en_o,
  output logic        ready_o
);
  fir3_state_e state_q, state_d;
  logic        ready_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CAPT: state_d = ST_CALC;
      ST_CALC: state_d = ST_ADD;
      ST_ADD:  state_d = ST_DROP;
      ST_DROP: state_d = ST_CAPT;
      default: state_d = ST_CAPT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CAPT;
    else        state_q <= state_d;
  end

  assign cap_en_o  = (state_q == ST_CAPT);
  assign calc_en_o = (state_q == ST_CALC);
  assign add_en_o  = (state_q == ST_ADD);

  // Flag rises on commit, falls in any other state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ready_q <= 1'b0;
    else if (add_en_o) ready_q <= 1'b1;
    else               ready_q <= 1'b0;
  end

  assign state_o = state_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/fir3_hist.sv
module fir3_hist #(
  parameter int unsigned W    = 24,
  parameter int unsigned TAPS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         add_en,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] tap_o [TAPS]
);
  // tap 0 is the captured sample, higher taps are older
  logic [W-1:0] tap_q [TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tap_q[0] <= '0;
    else if (cap_en) tap_q[0] <= sample_i;
  end

  for (genvar i = 1; i < TAPS; i++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tap_q[i] <= '0;
      else if (add_en) tap_q[i] <= tap_q[i-1];
    end
  end

  assign tap_o = tap_q;
endmodule

// File: rtl/fir3_mac.sv
module fir3_mac #(
  parameter int unsigned W    = 24,
  parameter int unsigned TAPS = 3,
  parameter logic [W-1:0] C0  = 24'h702A78,
  parameter logic [W-1:0] C1  = 24'h800000,
  parameter logic [W-1:0] C2  = 24'h4FD547
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         calc_en,
  input  logic         add_en,
  input  logic [W-1:0] tap_i [TAPS],
  output logic [W-1:0] result_o
);
  localparam logic [W-1:0] COEF [3] = '{C0, C1, C2};

  logic [W-1:0] prod_q [TAPS];
  logic [W-1:0] sum_d;
  logic [W-1:0] result_q;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prod_q[i] <= '0;
      else if (calc_en) prod_q[i] <= tap_i[i] * COEF[i];
    end
  end

  always_comb begin
    sum_d = '0;
    for (int i = 0; i < TAPS; i++) sum_d = sum_d + prod_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (add_en) result_q <= sum_d;
  end

  assign result_o = result_q;
endmodule

// File: rtl/fir3_seq.sv
module fir3_seq
  import fir3_pkg::*;
#(
  parameter int unsigned W  = FIR3_W,
  parameter logic [W-1:0] C0 = 24'h702A78,
  parameter logic [W-1:0] C1 = 24'h800000,
  parameter logic [W-1:0] C2 = 24'h4FD547
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] result_o,
  output logic         ready_o
);
  localparam int unsigned TAPS = FIR3_TAPS;

  logic         srst_n;
  fir3_state_e  state;
  logic         cap_en, calc_en, add_en;
  logic [W-1:0] taps [TAPS];

  fir3_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  fir3_ctrl u_ctrl (
    .clk(clk), .rst_n(srst_n), .state_o(state),
    .cap_en_o(cap_en), .calc_en_o(calc_en), .add_en_o(add_en),
    .ready_o(ready_o)
  );

  fir3_hist #(.W(W), .TAPS(TAPS)) u_hist (
    .clk(clk), .rst_n(srst_n), .cap_en(cap_en), .add_en(add_en),
    .sample_i(sample_i), .tap_o(taps)
  );

  fir3_mac #(.W(W), .TAPS(TAPS), .C0(C0), .C1(C1), .C2(C2)) u_mac (
    .clk(clk), .rst_n(srst_n), .calc_en(calc_en), .add_en(add_en),
    .tap_i(taps), .result_o(result_o)
  );
endmodule

// File: rtl/fir3_chk.sv
module fir3_chk
  import fir3_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input logic        clk,
  input logic        srst_n,
  input fir3_state_e state,
  input logic        ready,
  input logic [W-1:0] result
);
  // R3
  capt_to_calc_chk: assert property (@(posedge clk) disable iff (!srst_n)
    state == ST_CAPT |=> state == ST_CALC);
  // R3
  calc_to_add_chk: assert property (@(posedge clk) disable iff (!srst_n)
    state == ST_CALC |=> state == ST_ADD);
  // R3
  add_to_drop_chk: assert property (@(posedge clk) disable iff (!srst_n)
    state == ST_ADD |=> state == ST_DROP);
  // R3
  drop_to_capt_chk: assert property (@(posedge clk) disable iff (!srst_n)
    state == ST_DROP |=> state == ST_CAPT);
  // R4
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ready |=> !ready);
  // R4
  ready_phase_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ready |-> state == ST_DROP);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    state != ST_ADD |=> $stable(result));
endmodule

bind fir3_seq fir3_chk #(.W(W)) u_chk (
  .clk(clk), .srst_n(srst_n), .state(state), .ready(ready_o), .result(result_o)
);

// File: tb/tb_fir3_seq.sv
module tb_fir3_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] sample;
  logic [23:0] result;
  logic        ready;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  logic [23:0] h1, h2, last_res;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fir3_seq dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample),
    .result_o(result), .ready_o(ready)
  );

  function automatic logic [23:0] model(input logic [23:0] a, b, c);
    logic [47:0] p0, p1, p2;
    logic [23:0] s;
    p0 = {24'h0, a} * 48'h702A78;
    p1 = {24'h0, b} * 48'h800000;
    p2 = {24'h0, c} * 48'h4FD547;
    s  = p0[23:0] + p1[23:0] + p2[23:0];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One sample through the loop; entered at a negedge in the drop state
  task automatic step(input logic [23:0] x, input bit first, input bit inject);
    int n;
    logic [23:0] exp;
    sample = x;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (inject && n == 2) sample = ~x;  // R5: post-capture change must be ignored
      if (!first && n == 1) check(ready == 1'b0, "R4 strobe width", {31'h0, ready}, 32'h0);
      if (!ready) check(result == last_res, "R7 hold", {8'h0, result}, {8'h0, last_res});
    end while (!ready && n < 16);
    exp = model(x, h1, h2);
    check(ready == 1'b1, "R3 strobe missing", {31'h0, ready}, 32'h1);
    if (!first) check(n == 4, "R3 period", n, 32'd4);
    check(result == exp, "R2 R5 R6 result", {8'h0, result}, {8'h0, exp});
    h2 = h1;
    h1 = x;
    last_res = result;
  endtask

  initial begin
    logic [23:0] lf;
    logic [23:0] edges [8];
    edges = '{24'h000000, 24'hFFFFFF, 24'h000001, 24'h800000,
              24'hFFFFFF, 24'hFFFFFF, 24'h7FFFFF, 24'h123456};
    rst_n = 1'b0;
    sample = 24'h0;
    h1 = '0; h2 = '0; last_res = '0;
    repeat (3) @(negedge clk);
    // R1
    check(result == 24'h0, "R1 reset result", {8'h0, result}, 32'h0);
    check(ready == 1'b0, "R1 reset ready", {31'h0, ready}, 32'h0);
    rst_n = 1'b1;
    // R1 R6: first outputs use zero history
    for (int i = 0; i < 8; i++) step(edges[i], i == 0, i != 0);
    lf = 24'hACE1F3;
    for (int i = 0; i < 80; i++) begin
      lf = lf[0] ? ((lf >> 1) ^ 24'hE10000) : (lf >> 1);
      step(lf, 1'b0, 1'b1);
    end
    // R8: asynchronous clear mid-stream
    #1 rst_n = 1'b0;
    #0.5;
    check(result == 24'h0, "R8 async result", {8'h0, result}, 32'h0);
    check(ready == 1'b0, "R8 async ready", {31'h0, ready}, 32'h0);
    h1 = '0; h2 = '0; last_res = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(24'hFFFFFF, 1'b1, 1'b0);
    step(24'hFFFFFF, 1'b0, 1'b1);
    step(24'hFFFFFF, 1'b0, 1'b1);
    step(24'h000003, 1'b0, 1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule